// File: doc/BRIEF.md
# Line-Delay FIFO with Independent Pointer Resets

This block is a single-clock sequential-access store that delays a stream of bytes by a programmable distance. A typical use is as a video line or field delay. Words go in at a write pointer and come out at a read pointer. The two pointers run independently of each other. Each one advances only on its own enabled cycles and wraps at the end of the array. No full or empty flags are produced. The distance between the pointers is set by the user, who chooses when to reset each one.

Neither pointer has a defined position at power-up. Each is initialised by its own active-low reset request, which is sampled on the rising clock edge. If the request lands on an enabled access cycle, that access uses address 0. If it lands on an idle cycle, it is remembered and applied to the next enabled access of that pointer. A single sampled edge is always enough.

Read data is registered: it appears one clock after the enabling edge. An output-enable forces the output to zero while it is inactive, which stands in for a released bus.

Top module: `linedly_fifo`

## Requirements
- R1: Words read back come out in the order they were written, starting from address 0 after each pointer has been reset.
- R2: A write with `wr_rst_n` low and `wr_en_n` low at the same edge stores its word at address 0, and the next enabled write goes to address 1.
- R3: A write reset sampled on an edge with `wr_en_n` high is held across any number of idle cycles. The next enabled write then goes to address 0. One sampled edge of the request is enough.
- R4: A read with `rd_rst_n` low and `rd_en_n` low at the same edge fetches address 0, and the next enabled read fetches address 1.
- R5: A read reset sampled on an edge with `rd_en_n` high is held pending. The next enabled read then fetches address 0.
- R6: A pointer moves only on edges where its enable is low. An edge with `wr_en_n` high stores nothing. An edge with `rd_en_n` high leaves `rd_data` unchanged.
- R7: After address DEPTH-1 (5119 by default), each pointer continues at address 0.
- R8: The word fetched at a read edge is present on `rd_data` right after that edge and stays there until the next enabled read.
- R9: While `rd_oe_n` is high, `rd_data` is all zeros. Reads still advance, and the fetched word appears once `rd_oe_n` goes low.
- R10: A write and a read to the same address at the same edge return the word stored before that edge.
- R11: A write reset does not move the read pointer, and a read reset does not move the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| wr_en_n | input | 1 | Write enable, active low |
| wr_rst_n | input | 1 | Write-pointer reset request, active low |
| wr_data | input | 8 | Word to store |
| rd_en_n | input | 1 | Read enable, active low |
| rd_rst_n | input | 1 | Read-pointer reset request, active low |
| rd_oe_n | input | 1 | Output enable, active low; zeros when high |
| rd_data | output | 8 | Registered read word |

## Verification
The bench exercises reset requests in three timings: on an idle edge followed by idle gaps, coincident with an access, and coincident with a same-address write. Together these separate a pending reset from an immediate one, and read-before-write from write-through. Enable-high cycles with changing data are placed between accesses, which exposes a pointer or memory that moves without being enabled. A write reset issued while the read pointer sits mid-array shows whether the two pointers are coupled. A full pass over 5121 writes and 5121 reads checks the wrap at both ends and the overwrite of address 0. Reads taken with the output disabled confirm that blanking does not stall the read pointer.

// File: rtl/linedly_pkg.sv
package linedly_pkg;

    localparam int unsigned LD_DEPTH = 5120;
    localparam int unsigned LD_WIDTH = 8;

    // Per-edge decision of a pointer unit.
    typedef enum logic [1:0] {
        PA_IDLE = 2'd0,   // no access, no request
        PA_ARM  = 2'd1,   // request on idle edge: remember it
        PA_STEP = 2'd2,   // access at current pointer
        PA_ZERO = 2'd3    // access at address 0 (reset applied)
    } ptr_act_e;

endpackage

// File: rtl/linedly_ptr.sv
module linedly_ptr
    import linedly_pkg::*;
#(
    parameter int unsigned DEPTH = LD_DEPTH,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          en_n,
    input  logic          rst_req_n,
    output logic [AW-1:0] addr,
    output logic          go,
    output logic          ready
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW-1:0] ONE  = AW'(1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          pend;
        logic          ok;
    } ptr_st_t;

    ptr_st_t  s_d, s_q;
    ptr_act_e act;

    always_comb begin
        s_d = s_q;
        act = PA_IDLE;
        if (!en_n) begin
            act = (!rst_req_n || s_q.pend) ? PA_ZERO : PA_STEP;
        end else if (!rst_req_n) begin
            act = PA_ARM;
        end

        addr = (act == PA_ZERO) ? '0 : s_q.ptr;
        go   = (act == PA_ZERO) || ((act == PA_STEP) && s_q.ok);

        case (act)
            PA_ARM: begin
                s_d.pend = 1'b1;
            end
            PA_ZERO: begin
                s_d.ptr  = ONE;
                s_d.pend = 1'b0;
                s_d.ok   = 1'b1;
            end
            PA_STEP: begin
                s_d.ptr = (s_q.ptr == LAST) ? '0 : s_q.ptr + ONE;
            end
            default: begin
            end
        endcase
    end

    // Pointers are deliberately left without a reset: undefined until initialised.
    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign ready = s_q.ok;

    AST_ZERO_THEN_ONE: assert property (@(posedge clk) disable iff (!s_q.ok)
        (!en_n && !rst_req_n) |=> (s_q.ptr == ONE && !s_q.pend)); // R2
    AST_PEND_ARMS: assert property (@(posedge clk) disable iff (!s_q.ok)
        (en_n && !rst_req_n) |=> s_q.pend); // R3
    AST_PEND_USED: assert property (@(posedge clk) disable iff (!s_q.ok)
        (!en_n && rst_req_n && s_q.pend) |=> (s_q.ptr == ONE && !s_q.pend)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!s_q.ok)
        en_n |=> $stable(s_q.ptr)); // R6
    AST_WRAP_END: assert property (@(posedge clk) disable iff (!s_q.ok)
        (!en_n && rst_req_n && !s_q.pend && s_q.ptr == LAST) |=> (s_q.ptr == '0)); // R7

endmodule

// File: rtl/linedly_mem.sv
module linedly_mem
    import linedly_pkg::*;
#(
    parameter int unsigned DEPTH = LD_DEPTH,
    parameter int unsigned WIDTH = LD_WIDTH,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_go,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_go,
    input  logic [AW-1:0]    rd_addr,
    input  logic             both_ready,
    output logic [WIDTH-1:0] rd_word
);

    logic [WIDTH-1:0] store_q [DEPTH];
    logic [WIDTH-1:0] word_d, word_q;

    // Nonblocking update: a same-edge read sees the previous contents.
    always_ff @(posedge clk) begin
        if (wr_go) begin
            store_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        word_d = word_q;
        if (rd_go) begin
            word_d = store_q[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        word_q <= word_d;
    end

    assign rd_word = word_q;

    AST_RD_KEEP: assert property (@(posedge clk) disable iff (!both_ready)
        !rd_go |=> $stable(word_q)); // R8

endmodule

// File: rtl/linedly_fifo.sv
module linedly_fifo
    import linedly_pkg::*;
#(
    parameter int unsigned DEPTH = LD_DEPTH,
    parameter int unsigned WIDTH = LD_WIDTH,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en_n,
    input  logic             wr_rst_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en_n,
    input  logic             rd_rst_n,
    input  logic             rd_oe_n,
    output logic [WIDTH-1:0] rd_data
);

    logic [AW-1:0]    waddr, raddr;
    logic             wgo, rgo, wready, rready;
    logic [WIDTH-1:0] word;

    linedly_ptr #(.DEPTH(DEPTH)) u_wptr (
        .clk       (clk),
        .en_n      (wr_en_n),
        .rst_req_n (wr_rst_n),
        .addr      (waddr),
        .go        (wgo),
        .ready     (wready)
    );

    linedly_ptr #(.DEPTH(DEPTH)) u_rptr (
        .clk       (clk),
        .en_n      (rd_en_n),
        .rst_req_n (rd_rst_n),
        .addr      (raddr),
        .go        (rgo),
        .ready     (rready)
    );

    linedly_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk        (clk),
        .wr_go      (wgo),
        .wr_addr    (waddr),
        .wr_data    (wr_data),
        .rd_go      (rgo),
        .rd_addr    (raddr),
        .both_ready (wready && rready),
        .rd_word    (word)
    );

    assign rd_data = rd_oe_n ? '0 : word;

endmodule

// File: tb/linedly_fifo_bench.sv
module linedly_fifo_bench;

    localparam int DEPTH = 5120;

    logic       clk = 1'b0;
    logic       wr_en_n, wr_rst_n, rd_en_n, rd_rst_n, rd_oe_n;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    int         n_chk = 0;
    int         n_err = 0;

    always #10 clk = ~clk;

    linedly_fifo u_linedly_fifo (
        .clk      (clk),
        .wr_en_n  (wr_en_n),
        .wr_rst_n (wr_rst_n),
        .wr_data  (wr_data),
        .rd_en_n  (rd_en_n),
        .rd_rst_n (rd_rst_n),
        .rd_oe_n  (rd_oe_n),
        .rd_data  (rd_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, return at the next falling edge.
    task automatic step(input logic we_n, input logic wr_n, input logic [7:0] d,
                        input logic re_n, input logic rr_n, input logic oe_n);
        wr_en_n  = we_n;
        wr_rst_n = wr_n;
        wr_data  = d;
        rd_en_n  = re_n;
        rd_rst_n = rr_n;
        rd_oe_n  = oe_n;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] wval(input int i);
        return 8'((i * 7) + 3);
    endfunction

    task automatic t_pending_init;
        step(1, 0, 8'hEE, 1, 1, 1);                          // write reset on idle edge
        chk("R9 blank while oe high", rd_data, 8'h00);
        for (int k = 0; k < 3; k++) step(1, 1, 8'hEE, 1, 1, 1);
        for (int i = 0; i < 8; i++) step(0, 1, 8'h10 + 8'(i), 1, 1, 1);
        step(1, 1, 8'h00, 1, 0, 0);                          // read reset on idle edge
        step(1, 1, 8'h00, 1, 1, 0);
        for (int i = 0; i < 8; i++) begin
            step(1, 1, 8'h00, 0, 1, 0);
            chk("R3 R5 R1 R8 pending-reset order", rd_data, 8'h10 + 8'(i));
        end
    endtask

    task automatic t_coincide;
        step(0, 0, 8'hA0, 1, 1, 0);                          // R2: write at addr 0
        step(0, 1, 8'hB1, 1, 1, 0);
        step(1, 1, 8'h00, 0, 0, 0);
        chk("R4 coincident read reset", rd_data, 8'hA0);
        step(1, 1, 8'h00, 0, 1, 0);
        chk("R2 second write at addr 1", rd_data, 8'hB1);
        step(1, 1, 8'h00, 0, 1, 0);
        chk("R1 addr 2 untouched", rd_data, 8'h12);
    endtask

    task automatic t_idle_hold;
        step(0, 0, 8'hC0, 1, 1, 0);
        step(1, 1, 8'hEE, 1, 1, 0);                          // disabled write, data changes
        step(0, 1, 8'hC1, 1, 1, 0);
        step(1, 1, 8'h00, 0, 0, 0);
        chk("R6 first word", rd_data, 8'hC0);
        step(1, 1, 8'h00, 1, 1, 0);
        chk("R6 R8 output held on idle read", rd_data, 8'hC0);
        step(1, 1, 8'h00, 1, 1, 0);
        chk("R6 R8 still held", rd_data, 8'hC0);
        step(1, 1, 8'h00, 0, 1, 0);
        chk("R6 disabled write stored nothing", rd_data, 8'hC1);
    endtask

    task automatic t_oe;
        step(1, 1, 8'h00, 0, 0, 1);
        chk("R9 zeros while oe high", rd_data, 8'h00);
        step(1, 1, 8'h00, 1, 1, 0);
        chk("R9 word shown after oe low", rd_data, 8'hC0);
        step(1, 1, 8'h00, 0, 1, 1);
        chk("R9 zeros on second read", rd_data, 8'h00);
        step(1, 1, 8'h00, 1, 1, 0);
        chk("R9 read advanced while blanked", rd_data, 8'hC1);
    endtask

    task automatic t_indep;
        step(1, 1, 8'h00, 0, 0, 0);
        chk("R11 read at addr 0", rd_data, 8'hC0);
        step(0, 0, 8'hD0, 1, 1, 0);                          // write reset mid-read
        step(0, 1, 8'hD1, 1, 1, 0);
        step(1, 1, 8'h00, 0, 1, 0);
        chk("R11 read pointer unmoved by write reset", rd_data, 8'hD1);
    endtask

    task automatic t_same_addr;
        step(0, 0, 8'hE0, 0, 0, 0);
        chk("R10 read-before-write", rd_data, 8'hD0);
        step(1, 1, 8'h00, 0, 0, 0);
        chk("R10 new word stored", rd_data, 8'hE0);
    endtask

    task automatic t_wrap;
        int bad;
        step(0, 0, wval(0), 1, 1, 0);
        for (int i = 1; i < DEPTH; i++) step(0, 1, wval(i), 1, 1, 0);
        step(0, 1, 8'h5A, 1, 1, 0);                          // R7: lands on addr 0
        step(1, 1, 8'h00, 0, 0, 0);
        chk("R7 write wrapped to addr 0", rd_data, 8'h5A);
        bad = 0;
        for (int i = 1; i < DEPTH; i++) begin
            step(1, 1, 8'h00, 0, 1, 0);
            if (rd_data !== wval(i)) begin
                if (bad == 0) chk("R1 R7 full pass", rd_data, wval(i));
                bad++;
            end
        end
        if (bad == 0) chk("R1 R7 full pass", 8'h00, 8'h00);
        step(1, 1, 8'h00, 0, 1, 0);
        chk("R7 read wrapped to addr 0", rd_data, 8'h5A);
    endtask

    initial begin
        wr_en_n  = 1'b1;
        wr_rst_n = 1'b1;
        rd_en_n  = 1'b1;
        rd_rst_n = 1'b1;
        rd_oe_n  = 1'b1;
        wr_data  = 8'h00;
        @(negedge clk);
        t_pending_init();
        t_coincide();
        t_idle_hold();
        t_oe();
        t_indep();
        t_same_addr();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule